// File: doc/BRIEF.md
# Real-Time Clock Timer Controller

This block is the counting core of a real-time clock. A 32-bit counter advances once for every pulse on a slow tick input. The tick is a clock enable in the system clock domain that comes from the low-frequency oscillator. An 8-bit control register sets up the core: the oscillator gate, timer run and alarm enable, and two self-clearing commands. One command loads the counter from a bus-side holding register. The other copies the counter into that holding register. Both commands complete on the next tick, so software watches the command bit to know when the transfer has taken place.

A 32-bit compare register drives a short alarm event. The alarm event can also return the counter to zero on the following tick. A missing-tick detector counts system clocks between ticks. It latches a sticky failure flag when the gap reaches a programmable limit.

Software reaches the core through a single-cycle write port and a combinational read port. Each port selects the control, holding or compare register with a 2-bit select.

Top module: `rtc_timer_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and the counter, holding and compare registers read 0.
- R2: The control byte layout is as follows:
  - bit 7: oscillator enable
  - bit 6: detector enable
  - bit 5: fail flag
  - bit 4: run
  - bit 3: alarm enable
  - bit 2: alarm flag on read, auto-reset enable on write
  - bit 1: set command
  - bit 0: capture command
- R3: The counter advances by exactly one on each tick when both run and oscillator enable are 1. It holds its value when either of them is 0, and it never changes on a cycle without a tick.
- R4: Writing 1 to bit 1 makes bit 1 read 1 until the next gated tick. On that tick the counter takes the holding value and bit 1 returns to 0.
- R5: Writing 1 to bit 0 makes bit 0 read 1 until the next gated tick. On that tick the holding register takes the counter value and bit 0 returns to 0.
- R6: With alarm enable set, a tick that advances the counter onto the compare value raises the alarm flag. The flag appears on `alarm_evt` and in control bit 2, and it clears on the following tick.
- R7: Any write to the control register clears the alarm flag.
- R8: The auto-reset enable written through bit 2 is held apart from the flag and is not read back. While it is 1, the tick after an alarm clears the counter to 0 instead of incrementing it.
- R9: With both detector enable and oscillator enable set, a run of FAIL_LIMIT system clocks with no tick sets the fail flag (default limit 256). A detector that is disabled never sets the flag.
- R10: The fail flag stays set until software writes 0 to bit 5. Writing 1 to bit 5 has no effect on it.
- R11: The read select chooses among four values:
  - 0: the control byte, zero-extended
  - 1: the holding register
  - 2: the compare register
  - 3: zero

  The write select uses the same codes for the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timer clock enable, one system cycle per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 holding, 2 compare |
| wr_data | input | 32 | Write data; the control register takes bits 7:0 |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 32 | Selected register value |
| alarm_evt | output | 1 | Alarm event flag |
| tmr_value | output | 32 | Current counter value |

## Verification
The bound checker watches the following on every cycle:
- the counter never moves without a gated tick, and it holds when stopped;
- a set or capture completes on the tick and transfers the right value;
- the alarm flag only rises on a compare match and drops on a control write or on the following tick;
- the auto-reset clears the counter;
- the fail flag only rises on a detector timeout and then stays set.

Only the bench scenarios can show the control-byte layout and read map as software sees them. They also show that the auto-reset bit is hidden on read, that the detector stays quiet while ticks arrive or while it is disabled, and that busy bits stay visible across the wait for a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CTRL_W = 8;
  localparam int B_OSC  = 7;
  localparam int B_DET  = 6;
  localparam int B_FAIL = 5;
  localparam int B_RUN  = 4;
  localparam int B_AEN  = 3;
  localparam int B_FLAG = 2;
  localparam int B_SET  = 1;
  localparam int B_CAP  = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HOLD = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtc_ctrl_bits.sv
module rtc_ctrl_bits
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] wr_byte,
  input  logic              eff_tick,
  input  logic              miss_to,
  output logic              osc_en,
  output logic              det_en,
  output logic              run_en,
  output logic              alarm_en,
  output logic              auto_rst,
  output logic              set_busy,
  output logic              cap_busy,
  output logic              fail_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en   <= 1'b0;
      det_en   <= 1'b0;
      run_en   <= 1'b0;
      alarm_en <= 1'b0;
      auto_rst <= 1'b0;
    end else if (ctrl_wr) begin
      osc_en   <= wr_byte[B_OSC];
      det_en   <= wr_byte[B_DET];
      run_en   <= wr_byte[B_RUN];
      alarm_en <= wr_byte[B_AEN];
      auto_rst <= wr_byte[B_FLAG];
    end
  end

  // command bits: a written 1 is held until the next gated tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_busy <= 1'b0;
      cap_busy <= 1'b0;
    end else begin
      set_busy <= (set_busy && !eff_tick) || (ctrl_wr && wr_byte[B_SET]);
      cap_busy <= (cap_busy && !eff_tick) || (ctrl_wr && wr_byte[B_CAP]);
    end
  end

  // sticky failure flag: hardware sets it, software can only clear it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fail_flag <= 1'b0;
    else if (miss_to)
      fail_flag <= 1'b1;
    else if (ctrl_wr && !wr_byte[B_FAIL])
      fail_flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eff_tick,
  input  logic         osc_en,
  input  logic         run_en,
  input  logic         alarm_en,
  input  logic         auto_rst,
  input  logic         set_busy,
  input  logic         cap_busy,
  input  logic         hold_wr,
  input  logic         cmp_wr,
  input  logic         flag_clr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] cmp_q,
  output logic         alarm_flag
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur,
                                           input logic clr_to_zero);
    return clr_to_zero ? '0 : cur + W'(1);
  endfunction

  logic         do_set;
  logic         do_cap;
  logic         do_adv;
  logic [W-1:0] cnt_nxt;

  assign do_set  = eff_tick && set_busy;
  assign do_cap  = eff_tick && cap_busy;
  assign do_adv  = eff_tick && run_en && !set_busy;
  assign cnt_nxt = do_set ? hold_q :
                   do_adv ? advance(cnt_q, auto_rst && alarm_flag) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // a capture on the same cycle as a bus write wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (do_cap)  hold_q <= cnt_q;
    else if (hold_wr) hold_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_wr) cmp_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  alarm_flag <= 1'b0;
    else if (flag_clr || !osc_en) alarm_flag <= 1'b0;
    else if (eff_tick)           alarm_flag <= do_adv && alarm_en && (cnt_nxt == cmp_q);
  end
endmodule

// File: rtl/rtc_miss_det.sv
module rtc_miss_det #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic miss_to
);
  localparam int GW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [GW-1:0] LAST = GW'(LIMIT - 1);

  logic [GW-1:0] gap_q;

  assign miss_to = active && !tick && (gap_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= '0;
    else if (!active || tick || miss_to) gap_q <= '0;
    else                         gap_q <= gap_q + GW'(1);
  end
endmodule

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
  import rtc_pkg::*;
#(
  parameter int W          = 32,
  parameter int FAIL_LIMIT = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         alarm_evt,
  output logic [W-1:0] tmr_value
);
  logic eff_tick, ctrl_wr, hold_wr, cmp_wr;
  logic osc_en, det_en, run_en, alarm_en, auto_rst;
  logic set_busy, cap_busy, fail_flag, alarm_flag, miss_to;
  logic [W-1:0] cnt_q, hold_q, cmp_q;
  logic [CTRL_W-1:0] ctrl_rd;

  assign eff_tick = tick && osc_en;
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign hold_wr  = wr_en && (wr_sel == SEL_HOLD);
  assign cmp_wr   = wr_en && (wr_sel == SEL_CMP);

  rtc_ctrl_bits u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_byte(wr_data[CTRL_W-1:0]),
    .eff_tick(eff_tick), .miss_to(miss_to), .osc_en(osc_en), .det_en(det_en),
    .run_en(run_en), .alarm_en(alarm_en), .auto_rst(auto_rst),
    .set_busy(set_busy), .cap_busy(cap_busy), .fail_flag(fail_flag)
  );

  rtc_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .eff_tick(eff_tick), .osc_en(osc_en),
    .run_en(run_en), .alarm_en(alarm_en), .auto_rst(auto_rst),
    .set_busy(set_busy), .cap_busy(cap_busy), .hold_wr(hold_wr),
    .cmp_wr(cmp_wr), .flag_clr(ctrl_wr), .wr_data(wr_data),
    .cnt_q(cnt_q), .hold_q(hold_q), .cmp_q(cmp_q), .alarm_flag(alarm_flag)
  );

  rtc_miss_det #(.LIMIT(FAIL_LIMIT)) u_miss (
    .clk(clk), .rst_n(rst_n), .active(det_en && osc_en), .tick(tick),
    .miss_to(miss_to)
  );

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[B_OSC]  = osc_en;
    ctrl_rd[B_DET]  = det_en;
    ctrl_rd[B_FAIL] = fail_flag;
    ctrl_rd[B_RUN]  = run_en;
    ctrl_rd[B_AEN]  = alarm_en;
    ctrl_rd[B_FLAG] = alarm_flag;
    ctrl_rd[B_SET]  = set_busy;
    ctrl_rd[B_CAP]  = cap_busy;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL: rd_data = {{(W-CTRL_W){1'b0}}, ctrl_rd};
      SEL_HOLD: rd_data = hold_q;
      SEL_CMP:  rd_data = cmp_q;
      default:  rd_data = '0;
    endcase
  end

  assign alarm_evt = alarm_flag;
  assign tmr_value = cnt_q;
endmodule

// File: rtl/rtc_timer_ctrl_chk.sv
module rtc_timer_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         eff_tick,
  input logic         ctrl_wr,
  input logic [W-1:0] wr_data,
  input logic         run_en,
  input logic         alarm_en,
  input logic         auto_rst,
  input logic         set_busy,
  input logic         cap_busy,
  input logic         alarm_flag,
  input logic         fail_flag,
  input logic         miss_to,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] cmp_q
);
  a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_tick |=> $stable(cnt_q));
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && !run_en && !set_busy) |=> $stable(cnt_q));
  a_r4_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && set_busy) |=> (cnt_q == $past(hold_q)));
  a_r4_set_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && set_busy && !(ctrl_wr && wr_data[1])) |=> !set_busy);
  a_r5_cap_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && cap_busy) |=> (hold_q == $past(cnt_q)));
  a_r6_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> (alarm_en && cnt_q == cmp_q));
  a_r6_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && eff_tick) |=> (!alarm_flag || cnt_q != $past(cnt_q)));
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !alarm_flag);
  a_r8_auto_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_tick && alarm_flag && auto_rst && run_en && !set_busy) |=> (cnt_q == '0));
  a_r9_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(miss_to));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !(ctrl_wr && !wr_data[5])) |=> fail_flag);
endmodule

bind rtc_timer_ctrl rtc_timer_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eff_tick(eff_tick), .ctrl_wr(ctrl_wr),
  .wr_data(wr_data), .run_en(run_en), .alarm_en(alarm_en), .auto_rst(auto_rst),
  .set_busy(set_busy), .cap_busy(cap_busy), .alarm_flag(alarm_flag),
  .fail_flag(fail_flag), .miss_to(miss_to), .cnt_q(cnt_q), .hold_q(hold_q),
  .cmp_q(cmp_q)
);

// File: tb/sim_rtc_timer_ctrl.sv
module sim_rtc_timer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        alarm_evt;
  logic [31:0] tmr_value;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // item source: 0..3 read port select, 4 counter output, 5 alarm output
  typedef struct {
    string       req;
    int          src;
    logic [31:0] exp;
  } exp_item_t;
  exp_item_t exp_q[$];
  event sample_ev;

  always #4 clk = ~clk;

  rtc_timer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .alarm_evt(alarm_evt), .tmr_value(tmr_value)
  );

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        if (it.src == 4)      act = tmr_value;
        else if (it.src == 5) act = {31'd0, alarm_evt};
        else                  act = rd_data;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int src, input logic [31:0] exp, input string req);
    exp_item_t it;
    if (src < 4) rd_sel = src[1:0];
    it.req = req; it.src = src; it.exp = exp;
    exp_q.push_back(it);
    -> sample_ev;
    wait (exp_q.size() == 0);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      for (int k = 1; k < gap; k++) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state, R11 read map
    expect_val(0, 32'h00, "R1 ctrl reset");
    expect_val(1, 32'h0, "R1 hold reset");
    expect_val(2, 32'h0, "R1 cmp reset");
    expect_val(4, 32'h0, "R1 counter reset");
    // R3 counting
    reg_write(2'd0, 32'h90);
    expect_val(0, 32'h90, "R2 osc and run bits");
    ticks(5, 3);
    expect_val(4, 32'd5, "R3 five ticks");
    reg_write(2'd0, 32'h80);
    ticks(3, 2);
    expect_val(4, 32'd5, "R3 stopped holds");
    reg_write(2'd0, 32'h10);
    ticks(2, 2);
    expect_val(4, 32'd5, "R3 osc off holds");
    // R5 capture
    reg_write(2'd0, 32'h81);
    expect_val(0, 32'h81, "R5 capture busy visible");
    idle(5);
    expect_val(0, 32'h81, "R5 busy waits for tick");
    ticks(1, 1);
    expect_val(0, 32'h80, "R5 busy cleared");
    expect_val(1, 32'd5, "R5 holding got counter");
    // R4 set
    reg_write(2'd1, 32'h1000);
    expect_val(1, 32'h1000, "R11 hold readback");
    reg_write(2'd0, 32'h82);
    expect_val(0, 32'h82, "R4 set busy visible");
    expect_val(4, 32'd5, "R4 no load before tick");
    ticks(1, 1);
    expect_val(0, 32'h80, "R4 busy cleared");
    expect_val(4, 32'h1000, "R4 counter loaded");
    // R6 alarm
    reg_write(2'd2, 32'h1003);
    expect_val(2, 32'h1003, "R11 cmp readback");
    expect_val(3, 32'h0, "R11 unused select");
    reg_write(2'd0, 32'h98);
    ticks(2, 2);
    expect_val(5, 32'd0, "R6 no alarm before match");
    ticks(1, 3);
    expect_val(4, 32'h1003, "R6 counter at compare");
    expect_val(5, 32'd1, "R6 alarm output");
    expect_val(0, 32'h9C, "R6 flag in bit 2");
    ticks(1, 2);
    expect_val(5, 32'd0, "R6 flag gone after next tick");
    expect_val(4, 32'h1004, "R6 counting continues");
    // R7 write clears
    reg_write(2'd2, 32'h1005);
    ticks(1, 2);
    expect_val(5, 32'd1, "R7 alarm raised");
    reg_write(2'd0, 32'h98);
    expect_val(5, 32'd0, "R7 control write clears flag");
    // R8 auto reset
    reg_write(2'd2, 32'h1008);
    reg_write(2'd0, 32'h9C);
    expect_val(0, 32'h98, "R8 auto bit not read back");
    ticks(3, 2);
    expect_val(4, 32'h1008, "R8 reached compare");
    expect_val(5, 32'd1, "R8 alarm before clear");
    ticks(1, 2);
    expect_val(4, 32'h0, "R8 counter cleared");
    expect_val(5, 32'd0, "R8 flag dropped");
    // R9 detector
    reg_write(2'd0, 32'hC0);
    ticks(3, 100);
    expect_val(0, 32'hC0, "R9 no fail while ticking");
    idle(300);
    expect_val(0, 32'hE0, "R9 fail on missing tick");
    // R10 sticky
    reg_write(2'd0, 32'hA0);
    expect_val(0, 32'hA0, "R10 write 1 keeps fail");
    reg_write(2'd0, 32'h80);
    expect_val(0, 32'h80, "R10 write 0 clears fail");
    idle(300);
    expect_val(0, 32'h80, "R9 detector off stays clear");
    reg_write(2'd0, 32'h40);
    idle(300);
    expect_val(0, 32'h40, "R9 osc off stays clear");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule